// File: doc/BRIEF.md
# Enclave Debug Read Access Checker

This block carries out one privileged debug read of a word held in protected enclave memory. A request brings a linear address, a flag that selects 64-bit mode, the current privilege level and a segment-limit violation indication. The block first checks the request on its own. It then fetches the per-page metadata entry over a request/response port. If every check passes, it reads one aligned 64-bit word over a memory read port. Both ports use valid/ready handshakes on the request and on the response, so their latency can vary.

Each request ends with exactly one outcome, marked by a one-cycle `done` pulse. The outcome is one of four: a general-protection fault, a page fault, a soft "page not debuggable" return, or success with data. The checks run in a fixed order, and the first one that triggers decides the outcome. The soft return writes the flags and an error code but no data. Pages that hold version-array or shadow-stack contents never return their raw contents. They return a saturated value: all ones or zero.

Top module: `enclave_dbg_reader`

## Requirements
- R1: A request with a nonzero privilege level ends with fault code GP (fault encoding: 0 none, 1 GP, 2 PF). No metadata lookup and no memory read are issued.
- R2: In 64-bit mode the address must be 8-byte aligned. Otherwise it must be 4-byte aligned. A misaligned address gives GP. The same 4-aligned address that faults in 64-bit mode succeeds in 32-bit mode.
- R3: When several checks trigger, the outcome follows this order: privilege (GP), segment-limit violation (GP), alignment (GP), outside the protected region (PF), entry busy (GP), entry invalid (PF), page type (PF), pending/modified (soft), control-page offset (GP), owner debug attribute (GP).
- R4: An address below REGION_BASE, or at or above REGION_BASE + REGION_PAGES*4096, gives PF.
- R5: A metadata response with the busy bit set gives GP. A response whose valid bit is clear gives PF.
- R6: The allowed page type codes are 1 regular, 2 control, 3 version-array, 4 shadow-stack-first and 5 shadow-stack-rest. Codes 0, 6 and 7 give PF.
- R7: A pending or modified page gives no fault and issues no memory read. The block writes the flags with the zero flag set (flg_val bit 5) and reports err_code = ERR_NOT_DEBUGGABLE, and it does not write data.
- R8: On a control page (type 2), address bits [11:0] greater than or equal to CTRL_OFS_LIMIT give GP.
- R9: On a regular or control page, a clear debug attribute gives GP. Otherwise the block returns the raw word. The word is read at the address with bits [2:0] cleared. The result is all 64 bits in 64-bit mode. In 32-bit mode it is the half that address bit 2 selects (1 selects bits [63:32]), zero-extended.
- R10: On type 3, 4 or 5, the read word with bits [2:0] masked off is tested. If it is nonzero, the result is all ones at the active width (64 or 32 bits, the upper half zero). If it is zero, the result is zero. The debug attribute is not consulted.
- R11: On success err_code is 0, data_we and flg_we are high, and all six flag bits (zero, sign, overflow, adjust, parity, carry) are 0. On a fault, data_we, flg_we and err_code are all 0.
- R12: The read/write/execute bits of the metadata response never change the outcome or the data.
- R13: Every accepted request produces one `done` pulse lasting one cycle. req_ready is high only while idle. A metadata lookup is issued only after the request checks pass, and a memory read only after the metadata checks pass.
- R14: Synchronous reset returns the block to idle. A metadata or memory request that is not yet accepted stays asserted with a stable address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Debug read request strobe |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | AW | Linear address of the word |
| req_mode64 | input | 1 | 1: 64-bit mode, 0: 32-bit mode |
| req_cpl | input | 2 | Current privilege level |
| req_seg_viol | input | 1 | Segment limit or rights violation |
| md_req_valid | output | 1 | Metadata lookup request |
| md_req_ready | input | 1 | Metadata lookup accepted |
| md_req_page | output | AW-12 | Page number to look up |
| md_rsp_valid | input | 1 | Metadata response present |
| md_rsp_ready | output | 1 | Waiting for metadata response |
| md_rsp_entry_valid | input | 1 | Entry valid bit |
| md_rsp_type | input | 3 | Page type code |
| md_rsp_pending | input | 1 | Page pending bit |
| md_rsp_modified | input | 1 | Page modified bit |
| md_rsp_busy | input | 1 | Entry being changed by another operation |
| md_rsp_debug | input | 1 | Owning enclave debug attribute |
| md_rsp_rwx | input | 3 | Page permissions (ignored) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory read accepted |
| mem_req_addr | output | AW | 8-byte aligned word address |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rsp_ready | output | 1 | Waiting for read data |
| mem_rsp_data | input | 64 | Read word |
| done | output | 1 | One-cycle outcome pulse |
| fault | output | 2 | 0 none, 1 GP, 2 PF |
| data_we | output | 1 | Data result valid |
| data | output | 64 | Result word |
| flg_we | output | 1 | Flags and error code written |
| flg_val | output | 6 | {zero, sign, overflow, adjust, parity, carry} |
| err_code | output | EW | Error code |

## Verification
Random requests mix several things: privilege levels, segment violations, misaligned and out-of-region addresses, every page type code, busy, invalid, pending and modified entries, control-page offsets around the limit, and both debug attribute values. Handshake latency on both ports is also random. Each outcome is checked against a bench model of the check chain, so a wrong priority shows up as a wrong fault class on requests where several checks trigger. Directed cases pin each boundary separately. These cover the region edges, the offset equal to and just under the limit, the 32-bit half select, and words whose only set bits lie in the masked low three bits. Counting metadata and memory handshakes per request shows whether a lookup or read leaked past a decided fault.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_PF   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MD_REQ,
        ST_MD_WAIT,
        ST_MEM_REQ,
        ST_MEM_WAIT,
        ST_RESP
    } state_e;

    localparam logic [2:0] PG_REGULAR = 3'd1;
    localparam logic [2:0] PG_CONTROL = 3'd2;
    localparam logic [2:0] PG_VERSION = 3'd3;
    localparam logic [2:0] PG_SHSTK_F = 3'd4;
    localparam logic [2:0] PG_SHSTK_R = 3'd5;

endpackage

// File: rtl/dbr_entry_check.sv
module dbr_entry_check
    import dbr_pkg::*;
#(
    parameter int unsigned     AW           = 32,
    parameter longint unsigned REGION_BASE  = 64'h0010_0000,
    parameter longint unsigned REGION_PAGES = 16
) (
    input  logic [AW-1:0] addr,
    input  logic          mode64,
    input  logic [1:0]    cpl,
    input  logic          seg_viol,
    output fault_e        fault
);
    localparam longint unsigned REGION_END = REGION_BASE + REGION_PAGES * 64'd4096;

    logic        misaligned;
    logic        outside;
    logic [63:0] addr_w;

    always_comb begin
        addr_w     = 64'(addr);
        misaligned = mode64 ? (addr[2:0] != 3'b000) : (addr[1:0] != 2'b00);
        outside    = (addr_w < REGION_BASE) || (addr_w >= REGION_END);

        if (cpl != 2'd0) begin
            fault = FLT_GP;
        end else if (seg_viol) begin
            fault = FLT_GP;
        end else if (misaligned) begin
            fault = FLT_GP;
        end else if (outside) begin
            fault = FLT_PF;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/dbr_meta_check.sv
module dbr_meta_check
    import dbr_pkg::*;
#(
    parameter int unsigned CTRL_OFS_LIMIT = 72
) (
    input  logic [11:0] page_ofs,
    input  logic        entry_valid,
    input  logic [2:0]  page_type,
    input  logic        pending,
    input  logic        modified,
    input  logic        busy,
    input  logic        debug_attr,
    output fault_e      fault,
    output logic        soft_err,
    output logic        saturate
);
    localparam logic [11:0] LIMIT = 12'(CTRL_OFS_LIMIT);

    logic is_owned;
    logic is_slot;
    logic type_ok;

    always_comb begin
        is_owned = (page_type == PG_REGULAR) || (page_type == PG_CONTROL);
        is_slot  = (page_type == PG_VERSION) || (page_type == PG_SHSTK_F) ||
                   (page_type == PG_SHSTK_R);
        type_ok  = is_owned || is_slot;
        saturate = is_slot;
        soft_err = 1'b0;
        fault    = FLT_NONE;

        if (busy) begin
            fault = FLT_GP;
        end else if (!entry_valid) begin
            fault = FLT_PF;
        end else if (!type_ok) begin
            fault = FLT_PF;
        end else if (pending || modified) begin
            soft_err = 1'b1;
        end else if ((page_type == PG_CONTROL) && (page_ofs >= LIMIT)) begin
            fault = FLT_GP;
        end else if (is_owned && !debug_attr) begin
            fault = FLT_GP;
        end
    end

endmodule

// File: rtl/dbr_result_fmt.sv
module dbr_result_fmt (
    input  logic        mode64,
    input  logic        upper_half,
    input  logic        saturate,
    input  logic [63:0] word,
    output logic [63:0] result
);
    logic [63:0] masked;
    logic        nonzero;

    always_comb begin
        masked  = word & ~64'h7;
        nonzero = |masked;
        if (saturate) begin
            if (!nonzero) begin
                result = 64'd0;
            end else if (mode64) begin
                result = {64{1'b1}};
            end else begin
                result = {32'd0, {32{1'b1}}};
            end
        end else if (mode64) begin
            result = word;
        end else begin
            result = {32'd0, (upper_half ? word[63:32] : word[31:0])};
        end
    end

endmodule

// File: rtl/enclave_dbg_reader.sv
module enclave_dbg_reader
    import dbr_pkg::*;
#(
    parameter int unsigned        AW                 = 32,
    parameter int unsigned        EW                 = 16,
    parameter longint unsigned    REGION_BASE        = 64'h0010_0000,
    parameter longint unsigned    REGION_PAGES       = 16,
    parameter int unsigned        CTRL_OFS_LIMIT     = 72,
    parameter logic [EW-1:0]      ERR_NOT_DEBUGGABLE = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_mode64,
    input  logic [1:0]       req_cpl,
    input  logic             req_seg_viol,
    output logic             md_req_valid,
    input  logic             md_req_ready,
    output logic [AW-13:0]   md_req_page,
    input  logic             md_rsp_valid,
    output logic             md_rsp_ready,
    input  logic             md_rsp_entry_valid,
    input  logic [2:0]       md_rsp_type,
    input  logic             md_rsp_pending,
    input  logic             md_rsp_modified,
    input  logic             md_rsp_busy,
    input  logic             md_rsp_debug,
    input  logic [2:0]       md_rsp_rwx,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    output logic             mem_rsp_ready,
    input  logic [63:0]      mem_rsp_data,
    output logic             done,
    output logic [1:0]       fault,
    output logic             data_we,
    output logic [63:0]      data,
    output logic             flg_we,
    output logic [5:0]       flg_val,
    output logic [EW-1:0]    err_code
);

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] addr;
        logic          mode64;
        logic          sat;
        fault_e        flt;
        logic          dwe;
        logic [63:0]   dat;
        logic          fwe;
        logic          zf;
        logic [EW-1:0] err;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, addr: '0, mode64: 1'b0, sat: 1'b0, flt: FLT_NONE,
        dwe: 1'b0, dat: '0, fwe: 1'b0, zf: 1'b0, err: '0
    };

    regs_t  r_q, r_d;
    fault_e pre_fault;
    fault_e meta_fault;
    logic   meta_soft;
    logic   meta_sat;
    logic [63:0] fmt_data;
    logic   unused_rwx;

    assign unused_rwx = ^md_rsp_rwx;

    dbr_entry_check #(
        .AW           (AW),
        .REGION_BASE  (REGION_BASE),
        .REGION_PAGES (REGION_PAGES)
    ) u_entry (
        .addr     (req_addr),
        .mode64   (req_mode64),
        .cpl      (req_cpl),
        .seg_viol (req_seg_viol),
        .fault    (pre_fault)
    );

    dbr_meta_check #(
        .CTRL_OFS_LIMIT (CTRL_OFS_LIMIT)
    ) u_meta (
        .page_ofs    (r_q.addr[11:0]),
        .entry_valid (md_rsp_entry_valid),
        .page_type   (md_rsp_type),
        .pending     (md_rsp_pending),
        .modified    (md_rsp_modified),
        .busy        (md_rsp_busy),
        .debug_attr  (md_rsp_debug),
        .fault       (meta_fault),
        .soft_err    (meta_soft),
        .saturate    (meta_sat)
    );

    dbr_result_fmt u_fmt (
        .mode64     (r_q.mode64),
        .upper_half (r_q.addr[2]),
        .saturate   (r_q.sat),
        .word       (mem_rsp_data),
        .result     (fmt_data)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr   = req_addr;
                    r_d.mode64 = req_mode64;
                    r_d.sat    = 1'b0;
                    if (pre_fault != FLT_NONE) begin
                        r_d.flt = pre_fault;
                        r_d.st  = ST_RESP;
                    end else begin
                        r_d.st  = ST_MD_REQ;
                    end
                end
            end
            ST_MD_REQ: begin
                if (md_req_ready) begin
                    r_d.st = ST_MD_WAIT;
                end
            end
            ST_MD_WAIT: begin
                if (md_rsp_valid) begin
                    r_d.sat = meta_sat;
                    if (meta_fault != FLT_NONE) begin
                        r_d.flt = meta_fault;
                        r_d.st  = ST_RESP;
                    end else if (meta_soft) begin
                        r_d.fwe = 1'b1;
                        r_d.zf  = 1'b1;
                        r_d.err = ERR_NOT_DEBUGGABLE;
                        r_d.st  = ST_RESP;
                    end else begin
                        r_d.st  = ST_MEM_REQ;
                    end
                end
            end
            ST_MEM_REQ: begin
                if (mem_req_ready) begin
                    r_d.st = ST_MEM_WAIT;
                end
            end
            ST_MEM_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.dat = fmt_data;
                    r_d.dwe = 1'b1;
                    r_d.fwe = 1'b1;
                    r_d.zf  = 1'b0;
                    r_d.err = '0;
                    r_d.st  = ST_RESP;
                end
            end
            ST_RESP: begin
                r_d     = REGS_RST;
                r_d.st  = ST_IDLE;
            end
            default: begin
                r_d = REGS_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == ST_IDLE);
    assign md_req_valid  = (r_q.st == ST_MD_REQ);
    assign md_req_page   = r_q.addr[AW-1:12];
    assign md_rsp_ready  = (r_q.st == ST_MD_WAIT);
    assign mem_req_valid = (r_q.st == ST_MEM_REQ);
    assign mem_req_addr  = {r_q.addr[AW-1:3], 3'b000};
    assign mem_rsp_ready = (r_q.st == ST_MEM_WAIT);
    assign done          = (r_q.st == ST_RESP);
    assign fault         = r_q.flt;
    assign data_we       = r_q.dwe;
    assign data          = r_q.dat;
    assign flg_we        = r_q.fwe;
    assign flg_val       = {r_q.zf, 5'b00000};
    assign err_code      = r_q.err;

endmodule

// File: rtl/dbr_checker.sv
module dbr_checker #(
    parameter int unsigned   AW       = 32,
    parameter int unsigned   EW       = 16,
    parameter logic [EW-1:0] ERR_CODE = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_cpl,
    input logic          md_req_valid,
    input logic          md_req_ready,
    input logic [AW-13:0] md_req_page,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          done,
    input logic [1:0]    fault,
    input logic          data_we,
    input logic          flg_we,
    input logic [5:0]    flg_val,
    input logic [EW-1:0] err_code
);

    p_cpl_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_cpl != 2'd0) |=> done && (fault == 2'd1));

    p_soft_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && flg_we && flg_val[5] |-> (err_code == ERR_CODE) && !data_we && (fault == 2'd0));

    p_success_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && data_we |-> (fault == 2'd0) && flg_we && (flg_val == 6'd0) && (err_code == '0));

    p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && (fault != 2'd0) |-> !data_we && !flg_we && (err_code == '0));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !done && !md_req_valid && !mem_req_valid);

    p_md_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        md_req_valid && !md_req_ready |=> md_req_valid && $stable(md_req_page));

    p_mem_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

endmodule

bind enclave_dbg_reader dbr_checker #(
    .AW       (AW),
    .EW       (EW),
    .ERR_CODE (ERR_NOT_DEBUGGABLE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_cpl       (req_cpl),
    .md_req_valid  (md_req_valid),
    .md_req_ready  (md_req_ready),
    .md_req_page   (md_req_page),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .data_we       (data_we),
    .flg_we        (flg_we),
    .flg_val       (flg_val),
    .err_code      (err_code)
);

// File: tb/sim_enclave_dbg_reader.sv
module sim_enclave_dbg_reader;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int EW = 16;
    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam int PAGES = 16;
    localparam logic [31:0] ENDA = BASE + PAGES * 4096;
    localparam int LIMIT = 72;
    localparam logic [15:0] ERRC = 16'd13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_mode64 = 1'b0;
    logic [1:0] req_cpl = 2'd0;
    logic req_seg_viol = 1'b0;
    logic md_req_valid;
    logic md_req_ready = 1'b0;
    logic [AW-13:0] md_req_page;
    logic md_rsp_valid = 1'b0;
    logic md_rsp_ready;
    logic md_rsp_entry_valid = 1'b0;
    logic [2:0] md_rsp_type = 3'd0;
    logic md_rsp_pending = 1'b0;
    logic md_rsp_modified = 1'b0;
    logic md_rsp_busy = 1'b0;
    logic md_rsp_debug = 1'b0;
    logic [2:0] md_rsp_rwx = 3'd0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic mem_rsp_ready;
    logic [63:0] mem_rsp_data = '0;
    logic done;
    logic [1:0] fault;
    logic data_we;
    logic [63:0] data;
    logic flg_we;
    logic [5:0] flg_val;
    logic [EW-1:0] err_code;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enclave_dbg_reader #(
        .AW(AW), .EW(EW), .REGION_BASE(64'(BASE)), .REGION_PAGES(PAGES),
        .CTRL_OFS_LIMIT(LIMIT), .ERR_NOT_DEBUGGABLE(ERRC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mode64(req_mode64), .req_cpl(req_cpl),
        .req_seg_viol(req_seg_viol), .md_req_valid(md_req_valid),
        .md_req_ready(md_req_ready), .md_req_page(md_req_page),
        .md_rsp_valid(md_rsp_valid), .md_rsp_ready(md_rsp_ready),
        .md_rsp_entry_valid(md_rsp_entry_valid), .md_rsp_type(md_rsp_type),
        .md_rsp_pending(md_rsp_pending), .md_rsp_modified(md_rsp_modified),
        .md_rsp_busy(md_rsp_busy), .md_rsp_debug(md_rsp_debug),
        .md_rsp_rwx(md_rsp_rwx), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
        .data_we(data_we), .data(data), .flg_we(flg_we), .flg_val(flg_val),
        .err_code(err_code)
    );

    typedef struct {
        logic [31:0] addr; logic m64; logic [1:0] cpl; logic seg;
        logic busy; logic vld; logic [2:0] ty; logic pend; logic mdf;
        logic dbg; logic [2:0] rwx; logic [63:0] word;
    } txn_t;

    typedef struct {
        logic [1:0] flt; logic md; logic mem; logic dwe; logic [63:0] dat;
        logic fwe; logic zf; logic [15:0] err; string tag;
    } exp_t;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input txn_t t);
        exp_t e;
        logic mis, outs, owned, slot;
        logic [63:0] w;
        e = '{flt: 2'd0, md: 1'b0, mem: 1'b0, dwe: 1'b0, dat: 64'd0,
              fwe: 1'b0, zf: 1'b0, err: 16'd0, tag: "R9"};
        mis   = t.m64 ? (t.addr[2:0] != 0) : (t.addr[1:0] != 0);
        outs  = (t.addr < BASE) || (t.addr >= ENDA);
        owned = (t.ty == 3'd1) || (t.ty == 3'd2);
        slot  = (t.ty >= 3'd3) && (t.ty <= 3'd5);
        if (t.cpl != 0) begin e.flt = 2'd1; e.tag = "R1"; end
        else if (t.seg) begin e.flt = 2'd1; e.tag = "R3"; end
        else if (mis) begin e.flt = 2'd1; e.tag = "R2"; end
        else if (outs) begin e.flt = 2'd2; e.tag = "R4"; end
        else begin
            e.md = 1'b1;
            if (t.busy) begin e.flt = 2'd1; e.tag = "R5"; end
            else if (!t.vld) begin e.flt = 2'd2; e.tag = "R5"; end
            else if (!(owned || slot)) begin e.flt = 2'd2; e.tag = "R6"; end
            else if (t.pend || t.mdf) begin
                e.fwe = 1'b1; e.zf = 1'b1; e.err = ERRC; e.tag = "R7";
            end
            else if (t.ty == 3'd2 && t.addr[11:0] >= LIMIT) begin e.flt = 2'd1; e.tag = "R8"; end
            else if (owned && !t.dbg) begin e.flt = 2'd1; e.tag = "R9"; end
            else begin
                e.mem = 1'b1; e.dwe = 1'b1; e.fwe = 1'b1;
                if (slot) begin
                    e.tag = "R10";
                    w = t.word & ~64'h7;
                    e.dat = (w == 0) ? 64'd0 : (t.m64 ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF);
                end else begin
                    e.dat = t.m64 ? t.word :
                            {32'd0, (t.addr[2] ? t.word[63:32] : t.word[31:0])};
                end
            end
        end
        return e;
    endfunction

    task automatic run_txn(input txn_t t, input string ftag);
        exp_t e;
        string tg;
        int md_seen, mem_seen, guard, md_dly, mem_dly;
        bit got, md_arm, mem_arm;
        logic [31:0] mem_a;
        logic [1:0] a_flt; logic a_dwe, a_fwe; logic [63:0] a_dat;
        logic [5:0] a_fv; logic [15:0] a_err;
        e = model(t);
        tg = (ftag == "") ? e.tag : ftag;
        md_seen = 0; mem_seen = 0; guard = 0; got = 0; md_arm = 0; mem_arm = 0;
        md_dly = 0; mem_dly = 0; mem_a = '0;
        a_flt = '0; a_dwe = 0; a_fwe = 0; a_dat = '0; a_fv = '0; a_err = '0;
        while (!req_ready && guard < 50) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_addr = t.addr; req_mode64 = t.m64;
        req_cpl = t.cpl; req_seg_viol = t.seg;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!got && guard < 200) begin
            guard++;
            if (done) begin
                got = 1; a_flt = fault; a_dwe = data_we; a_dat = data;
                a_fwe = flg_we; a_fv = flg_val; a_err = err_code;
            end else begin
                md_rsp_valid = 1'b0;
                mem_rsp_valid = 1'b0;
                if (md_arm) begin
                    if (md_dly == 0) begin
                        md_rsp_valid = 1'b1; md_arm = 0;
                        md_rsp_entry_valid = t.vld; md_rsp_type = t.ty;
                        md_rsp_pending = t.pend; md_rsp_modified = t.mdf;
                        md_rsp_busy = t.busy; md_rsp_debug = t.dbg; md_rsp_rwx = t.rwx;
                    end else md_dly--;
                end
                if (mem_arm) begin
                    if (mem_dly == 0) begin
                        mem_rsp_valid = 1'b1; mem_arm = 0; mem_rsp_data = t.word;
                    end else mem_dly--;
                end
                md_req_ready = 1'b0;
                if (md_req_valid && ($urandom % 2 == 0)) begin
                    md_req_ready = 1'b1; md_arm = 1; md_dly = $urandom % 3; md_seen++;
                end
                mem_req_ready = 1'b0;
                if (mem_req_valid && ($urandom % 2 == 0)) begin
                    mem_req_ready = 1'b1; mem_arm = 1; mem_dly = $urandom % 3;
                    mem_seen++; mem_a = mem_req_addr;
                end
                @(negedge clk);
            end
        end
        md_req_ready = 1'b0; mem_req_ready = 1'b0;
        md_rsp_valid = 1'b0; mem_rsp_valid = 1'b0;
        chk("R13", "done seen", 64'(got), 64'd1);
        chk(tg, "fault", 64'(a_flt), 64'(e.flt));
        chk(tg, "data_we", 64'(a_dwe), 64'(e.dwe));
        if (e.dwe) chk(tg, "data", a_dat, e.dat);
        chk(tg, "flg_we", 64'(a_fwe), 64'(e.fwe));
        chk(e.fwe ? "R11" : tg, "flags", 64'(a_fv), 64'({e.zf, 5'b0}));
        chk(e.zf ? "R7" : "R11", "err_code", 64'(a_err), 64'(e.err));
        chk("R13", "md lookups", 64'(md_seen), 64'(e.md));
        chk("R13", "mem reads", 64'(mem_seen), 64'(e.mem));
        if (e.mem) chk("R9", "mem addr", 64'(mem_a), 64'({t.addr[31:3], 3'b000}));
        @(negedge clk);
        chk("R13", "done width", 64'(done), 64'd0);
        chk("R13", "ready after", 64'(req_ready), 64'd1);
    endtask

    function automatic txn_t good();
        txn_t t;
        t = '{addr: BASE + 32'h2010, m64: 1'b1, cpl: 2'd0, seg: 1'b0, busy: 1'b0,
              vld: 1'b1, ty: 3'd1, pend: 1'b0, mdf: 1'b0, dbg: 1'b1, rwx: 3'd0,
              word: 64'h1122_3344_5566_7788};
        return t;
    endfunction

    function automatic txn_t rnd();
        txn_t t;
        int pg;
        pg = $urandom % (PAGES + 2);
        t = good();
        t.m64 = $urandom % 2;
        t.addr = BASE + 32'(pg) * 4096 - 4096 + 32'($urandom % 4096);
        if ($urandom % 4 == 0) t.addr[11:0] = 12'(LIMIT - 8 + 4 * ($urandom % 4));
        if ($urandom % 8 != 0) t.addr[2:0] = t.m64 ? 3'b000 : {t.addr[2], 2'b00};
        t.cpl  = ($urandom % 10 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
        t.seg  = ($urandom % 16 == 0);
        t.busy = ($urandom % 16 == 0);
        t.vld  = ($urandom % 16 != 0);
        t.ty   = ($urandom % 6 == 0) ? 3'($urandom % 8) : 3'(1 + $urandom % 5);
        t.pend = ($urandom % 8 == 0);
        t.mdf  = ($urandom % 8 == 0);
        t.dbg  = ($urandom % 8 != 0);
        t.rwx  = 3'($urandom % 8);
        t.word = ($urandom % 4 == 0) ? 64'($urandom % 8) : {$urandom, $urandom};
        return t;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        txn_t t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R14", "reset ready", 64'(req_ready), 64'd1);
        chk("R14", "reset done", 64'(done), 64'd0);
        chk("R14", "reset md req", 64'(md_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_txn(good(), "R9");
        t = good(); t.m64 = 0; run_txn(t, "R9");
        t = good(); t.m64 = 0; t.addr = t.addr + 4; run_txn(t, "R9");
        t = good(); t.rwx = 3'd7; run_txn(t, "R12");
        t = good(); t.rwx = 3'd5; t.ty = 3'd3; run_txn(t, "R12");
        t = good(); t.cpl = 2'd3; run_txn(t, "R1");
        t = good(); t.addr = t.addr + 4; run_txn(t, "R2");
        t = good(); t.addr = t.addr + 4; t.m64 = 0; run_txn(t, "R2");
        t = good(); t.addr = t.addr + 2; t.m64 = 0; run_txn(t, "R2");
        t = good(); t.addr = BASE - 8; run_txn(t, "R4");
        t = good(); t.addr = ENDA - 8; run_txn(t, "R4");
        t = good(); t.addr = ENDA; run_txn(t, "R4");
        t = good(); t.busy = 1; run_txn(t, "R5");
        t = good(); t.vld = 0; run_txn(t, "R5");
        t = good(); t.ty = 3'd0; run_txn(t, "R6");
        t = good(); t.ty = 3'd6; run_txn(t, "R6");
        t = good(); t.ty = 3'd7; run_txn(t, "R6");
        t = good(); t.pend = 1; run_txn(t, "R7");
        t = good(); t.mdf = 1; run_txn(t, "R7");
        t = good(); t.ty = 3'd2; t.addr[11:0] = 12'(LIMIT); run_txn(t, "R8");
        t = good(); t.ty = 3'd2; t.addr[11:0] = 12'(LIMIT - 8); run_txn(t, "R8");
        t = good(); t.dbg = 0; run_txn(t, "R9");
        t = good(); t.dbg = 0; t.ty = 3'd4; run_txn(t, "R10");
        t = good(); t.ty = 3'd3; t.word = 64'h7; run_txn(t, "R10");
        t = good(); t.ty = 3'd5; t.word = 64'h8; run_txn(t, "R10");
        t = good(); t.ty = 3'd4; t.word = 64'h8; t.m64 = 0; run_txn(t, "R10");
        t = good(); t.addr = BASE - 4; run_txn(t, "R3");
        t = good(); t.cpl = 2'd1; t.addr = ENDA; run_txn(t, "R3");
        t = good(); t.busy = 1; t.vld = 0; run_txn(t, "R3");
        t = good(); t.pend = 1; t.ty = 3'd2; t.addr[11:0] = 12'hFF0; run_txn(t, "R3");
        t = good(); t.mdf = 1; t.dbg = 0; run_txn(t, "R3");
        t = good(); t.seg = 1; t.addr = t.addr + 1; run_txn(t, "R3");

        for (int i = 0; i < 300; i++) begin
            run_txn(rnd(), "");
        end

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R14", "re-reset ready", 64'(req_ready), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule